// File: doc/BRIEF.md
# GPU L1 Line State Controller

This block tracks the coherence state of every line of a small GPU first-level data cache and decides, for each incoming event, what happens to that line and which actions must follow. Events come from three sources: the core (load, store, spill store, atomic, flush, evict), the L2 response path (read acknowledgement, write-back acknowledgement) and the replacement logic (victim eviction). Exactly one event is consumed per cycle.

For the consumed event the block writes the new state and dirty-byte mask of the line. One cycle after the handshake it presents the new state together with a set of action strobes. The strobes cover allocate, invalidate, the four kinds of completion to the core, a write-through request that carries the line's dirty bytes, and a forwarded request (block read or atomic). Core requests to a line that is waiting on an atomic are held off through the ready signal. The data array, the tags, the replacement choice and the network stay outside; the line address doubles as the line index.

Top module: `l1_line_ctrl`

## Requirements
- R1: After reset every line is invalid (state code 0), no strobe is active and `core_ready` is high; state codes are invalid=0, valid=1, written=2, written-and-valid=3, local=4, atomic-pending=5, and the dirty mask of a line in state 0, 1 or 5 is zero.
- R2: A load to a line in state 1, 3 or 4 raises `cpl_load` only; a load in state 0 sends a block read (`fwd_valid`, `fwd_atomic`=0, `fwd_mask` all ones) and the line stays 0. A read acknowledgement moves 0 to 1 with `act_alloc` and `cpl_load`, keeps 1 and 4 with `cpl_load`, and moves 2 or 3 to 3 with `cpl_load`.
- R3: A store with `wb_mode`=1 and `bypass_mode`=0 raises `cpl_store`, ORs its mask into the dirty mask, and moves 0 to 2 (with `act_alloc`) and 1 to 3, while 2, 3 and 4 keep their state.
- R4: A store with `wb_mode`=0 or `bypass_mode`=1 to a line in state 0, 1 or 4 raises `cpl_store`, sends a write-through whose mask is the old dirty mask ORed with the store mask, raises `act_inval` (and `act_alloc` from state 0) and leaves the line in state 0; in state 2 or 3 it acts as a write-back store.
- R5: A spill store (op 2, `bypass_mode`=0) to a line in state 0, 1 or 4 moves it to state 4 with `cpl_store`, merges the mask and sends no request; `act_alloc` is raised from state 0 only.
- R6: An atomic sends a forwarded atomic carrying the request mask and moves the line to state 5; from state 2, 3 or 4 it also sends the old dirty mask as a write-through and raises `act_inval`.
- R7: In state 5, load, store, spill store and atomic are held off (`core_ready` low, no event); flush and evict are accepted.
- R8: A load to a line in state 2 sends the dirty mask as a write-through, raises `act_inval` and leaves the line in state 0; it raises `cpl_load` when the load mask lies inside the dirty mask and sends a block read otherwise.
- R9: A replacement of a line in state 2, 3 or 4 sends the dirty mask as a write-through, invalidates it and leaves state 0; in state 1 it invalidates to 0, in state 5 it raises `act_inval` and stays 5, and in state 0 it has no action.
- R10: A flush raises `cpl_flush`; in state 2 or 3 it also writes the dirty mask through, invalidates and leaves state 0, and in any other state the line is unchanged.
- R11: An evict raises `cpl_evict`; state 1 goes to 0 with `act_inval`, state 0 stays 0, state 2 or 3 goes to 2 keeping its mask, and state 4 or 5 is unchanged.
- R12: A read acknowledgement to a line in state 5 raises `cpl_store` and `act_inval` and returns it to 0; with `bypass_mode`=1 a read response raises `cpl_store` and returns 5 to 0, and in any other state raises `cpl_load` without allocating or changing state.
- R13: A response (always ready) wins over a replacement, which wins over a core request; a write-back acknowledgement changes nothing; core op codes are load=0, store=1, spill=2, atomic=3, flush=4, evict=5; results appear on the outputs one cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_mode | input | 1 | Stores take the write-back path when high |
| bypass_mode | input | 1 | Cache bypassed: stores write through, reads do not allocate |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Core request consumed this cycle |
| core_op | input | 3 | Core operation code |
| core_line | input | LINE_W | Line addressed by the core |
| core_mask | input | MASK_W | Byte mask of the core request |
| rsp_valid | input | 1 | L2 response present |
| rsp_ready | output | 1 | L2 response consumed (always high) |
| rsp_is_wback | input | 1 | Response is a write-back acknowledgement |
| rsp_line | input | LINE_W | Line of the response |
| repl_valid | input | 1 | Replacement of a victim line requested |
| repl_ready | output | 1 | Replacement consumed this cycle |
| repl_line | input | LINE_W | Victim line |
| evt_valid | output | 1 | An event was consumed in the previous cycle |
| evt_line | output | LINE_W | Line of that event, also the request address |
| evt_state | output | 3 | New state of that line |
| act_alloc | output | 1 | Line allocated |
| act_inval | output | 1 | Line data invalidated |
| cpl_load | output | 1 | Load completed to the core |
| cpl_store | output | 1 | Store completed to the core |
| cpl_flush | output | 1 | Flush completed to the core |
| cpl_evict | output | 1 | Evict completed to the core |
| wt_valid | output | 1 | Write-through request issued |
| wt_mask | output | MASK_W | Bytes carried by the write-through |
| fwd_valid | output | 1 | Block read or atomic request issued |
| fwd_atomic | output | 1 | Forwarded request is an atomic (else block read) |
| fwd_mask | output | MASK_W | Mask of the forwarded request |

## Verification
A wrong state or dirty mask in a line stays hidden until the next event to that line, and then shows in the very cycle after that handshake. It can appear as a wrong `evt_state`, a missing or extra completion, an allocate or invalidate strobe, or a write-through with the wrong bytes. The bench drives every state against every event kind with two mask patterns, one inside and one outside the dirty bytes. It reaches each state through a short prefix, so each stored value is read back through the ports at the next event. Held-off core requests are checked at the ready signal and by the absence of any event.

// File: rtl/l1ls_pkg.sv
// Shared types of the L1 line state controller.
// Assumes: state and core-op codes are visible at the block edge and fixed.
package l1ls_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,   // invalid
        ST_V = 3'd1,   // valid, read only
        ST_W = 3'd2,   // written, no clean copy
        ST_M = 3'd3,   // written and valid
        ST_L = 3'd4,   // local segment, modifiable
        ST_A = 3'd5    // atomic pending
    } line_st_e;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_SPILL  = 3'd2,
        OP_ATOMIC = 3'd3,
        OP_FLUSH  = 3'd4,
        OP_EVICT  = 3'd5
    } core_op_e;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_LOAD,
        EV_ST_WB,
        EV_ST_WT,
        EV_SPILL,
        EV_ATOMIC,
        EV_FLUSH,
        EV_EVICT,
        EV_REPL,
        EV_RD_ACK,
        EV_RD_BYP,
        EV_WB_ACK,
        EV_NOP
    } evt_e;

    typedef struct packed {
        logic alloc;
        logic inval;
        logic cpl_load;
        logic cpl_store;
        logic cpl_flush;
        logic cpl_evict;
        logic wt;
        logic fwd;
        logic fwd_atomic;
    } act_t;

endpackage

// File: rtl/l1ls_state_table.sv
// Per-line state and dirty-byte mask storage.
// One combinational read port, one write port; the write lands at the clock edge.
// Assumes: LINES is a power of two so every line index is in range.
module l1ls_state_table
    import l1ls_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int MASK_W = 4,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output line_st_e          rd_state,
    output logic [MASK_W-1:0] rd_mask,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  line_st_e          wr_state,
    input  logic [MASK_W-1:0] wr_mask
);

    line_st_e          st_q  [LINES];
    logic [MASK_W-1:0] msk_q [LINES];

    // Purpose: one state/mask register pair per line, cleared on reset.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= ST_I;
                msk_q[g] <= '0;
            end else if (wr_en && (wr_line == LINE_W'(g))) begin
                st_q[g]  <= wr_state;
                msk_q[g] <= wr_mask;
            end
        end
    end

    // Purpose: read the addressed line.
    always_comb begin
        rd_state = st_q[rd_line];
        rd_mask  = msk_q[rd_line];
    end

    // R1: clean, invalid and atomic-pending lines hold no dirty bytes.
    a_r1_clean_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state inside {ST_I, ST_V, ST_A}) |-> (rd_mask == '0));

endmodule

// File: rtl/l1ls_next.sv
// Transition function: from the current line state, its dirty mask and the
// event, computes the new state, the new mask and the actions to take.
// Purely combinational. Assumes data ops never reach it for a line in ST_A.
module l1ls_next
    import l1ls_pkg::*;
#(
    parameter int MASK_W = 4
) (
    input  evt_e              ev,
    input  line_st_e          cur_st,
    input  logic [MASK_W-1:0] cur_mask,
    input  logic [MASK_W-1:0] req_mask,
    output line_st_e          nxt_st,
    output logic [MASK_W-1:0] nxt_mask,
    output act_t              act,
    output logic [MASK_W-1:0] wt_mask,
    output logic [MASK_W-1:0] fwd_mask
);

    logic [MASK_W-1:0] merged;
    logic              covered;
    logic              dirty_st;   // W or M
    logic              store_ok;   // I, V or L

    // Purpose: helper terms shared by several events.
    always_comb begin
        merged   = cur_mask | req_mask;
        covered  = ((req_mask & ~cur_mask) == '0);
        dirty_st = (cur_st == ST_W) || (cur_st == ST_M);
        store_ok = (cur_st == ST_I) || (cur_st == ST_V) || (cur_st == ST_L);
    end

    // Purpose: per-event transition and action selection.
    always_comb begin
        nxt_st   = cur_st;
        nxt_mask = cur_mask;
        act      = '0;
        wt_mask  = '0;
        fwd_mask = '0;
        case (ev)
            EV_LOAD: begin
                if (cur_st == ST_I) begin
                    act.fwd  = 1'b1;
                    fwd_mask = '1;
                end else if (cur_st == ST_W) begin
                    act.wt    = 1'b1;
                    wt_mask   = cur_mask;
                    act.inval = 1'b1;
                    nxt_st    = ST_I;
                    nxt_mask  = '0;
                    if (covered) begin
                        act.cpl_load = 1'b1;
                    end else begin
                        act.fwd  = 1'b1;
                        fwd_mask = '1;
                    end
                end else if (cur_st != ST_A) begin
                    act.cpl_load = 1'b1;
                end
            end
            EV_ST_WB: begin
                if (cur_st != ST_A) begin
                    act.cpl_store = 1'b1;
                    nxt_mask      = merged;
                    if (cur_st == ST_I) begin
                        act.alloc = 1'b1;
                        nxt_st    = ST_W;
                    end else if (cur_st == ST_V) begin
                        nxt_st = ST_M;
                    end
                end
            end
            EV_ST_WT: begin
                if (store_ok) begin
                    act.cpl_store = 1'b1;
                    act.alloc     = (cur_st == ST_I);
                    act.wt        = 1'b1;
                    wt_mask       = merged;
                    act.inval     = 1'b1;
                    nxt_st        = ST_I;
                    nxt_mask      = '0;
                end else if (dirty_st) begin
                    act.cpl_store = 1'b1;
                    nxt_mask      = merged;
                end
            end
            EV_SPILL: begin
                if (store_ok) begin
                    act.cpl_store = 1'b1;
                    act.alloc     = (cur_st == ST_I);
                    nxt_st        = ST_L;
                    nxt_mask      = merged;
                end else if (dirty_st) begin
                    act.cpl_store = 1'b1;
                    nxt_mask      = merged;
                end
            end
            EV_ATOMIC: begin
                if (cur_st != ST_A) begin
                    act.fwd        = 1'b1;
                    act.fwd_atomic = 1'b1;
                    fwd_mask       = req_mask;
                    nxt_st         = ST_A;
                    nxt_mask       = '0;
                    if (dirty_st || (cur_st == ST_L)) begin
                        act.wt    = 1'b1;
                        wt_mask   = cur_mask;
                        act.inval = 1'b1;
                    end
                end
            end
            EV_FLUSH: begin
                act.cpl_flush = 1'b1;
                if (dirty_st) begin
                    act.wt    = 1'b1;
                    wt_mask   = cur_mask;
                    act.inval = 1'b1;
                    nxt_st    = ST_I;
                    nxt_mask  = '0;
                end
            end
            EV_EVICT: begin
                act.cpl_evict = 1'b1;
                if (cur_st == ST_V) begin
                    act.inval = 1'b1;
                    nxt_st    = ST_I;
                    nxt_mask  = '0;
                end else if (dirty_st) begin
                    nxt_st = ST_W;
                end
            end
            EV_REPL: begin
                if (dirty_st || (cur_st == ST_L)) begin
                    act.wt    = 1'b1;
                    wt_mask   = cur_mask;
                    act.inval = 1'b1;
                    nxt_st    = ST_I;
                    nxt_mask  = '0;
                end else if (cur_st == ST_V) begin
                    act.inval = 1'b1;
                    nxt_st    = ST_I;
                end else if (cur_st == ST_A) begin
                    act.inval = 1'b1;
                end
            end
            EV_RD_ACK: begin
                if (cur_st == ST_A) begin
                    act.cpl_store = 1'b1;
                    act.inval     = 1'b1;
                    nxt_st        = ST_I;
                    nxt_mask      = '0;
                end else begin
                    act.cpl_load = 1'b1;
                    if (cur_st == ST_I) begin
                        act.alloc = 1'b1;
                        nxt_st    = ST_V;
                    end else if (dirty_st) begin
                        nxt_st = ST_M;
                    end
                end
            end
            EV_RD_BYP: begin
                if (cur_st == ST_A) begin
                    act.cpl_store = 1'b1;
                    nxt_st        = ST_I;
                    nxt_mask      = '0;
                end else begin
                    act.cpl_load = 1'b1;
                end
            end
            default: begin
                // EV_NONE, EV_WB_ACK, EV_NOP: line untouched
            end
        endcase
    end

endmodule

// File: rtl/l1ls_issue.sv
// Output register stage: holds the result of the event consumed in the
// previous cycle. Assumes strobes are zero whenever no event fired.
module l1ls_issue
    import l1ls_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int MASK_W = 4,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [LINE_W-1:0] line_in,
    input  line_st_e          st_in,
    input  act_t              act_in,
    input  logic [MASK_W-1:0] wt_mask_in,
    input  logic [MASK_W-1:0] fwd_mask_in,
    output logic              evt_valid,
    output logic [LINE_W-1:0] evt_line,
    output line_st_e          evt_state,
    output act_t              act_q,
    output logic [MASK_W-1:0] wt_mask_q,
    output logic [MASK_W-1:0] fwd_mask_q
);

    // Purpose: register the event result; strobes drop when nothing fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid  <= 1'b0;
            evt_line   <= '0;
            evt_state  <= ST_I;
            act_q      <= '0;
            wt_mask_q  <= '0;
            fwd_mask_q <= '0;
        end else begin
            evt_valid  <= fire;
            evt_line   <= line_in;
            evt_state  <= st_in;
            act_q      <= fire ? act_in : '0;
            wt_mask_q  <= fire ? wt_mask_in : '0;
            fwd_mask_q <= fire ? fwd_mask_in : '0;
        end
    end

    // R4 / R8 / R9 / R10: a write-through always leaves the line without data.
    a_r4_wt_leaves_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
        act_q.wt |-> (evt_state inside {ST_I, ST_A}));

    // R6: a forwarded atomic always leaves the line pending.
    a_r6_atomic_enters_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.fwd && act_q.fwd_atomic) |-> (evt_state == ST_A));

    // R2 / R8: a block read is only sent for a line that ends invalid.
    a_r2_read_keeps_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.fwd && !act_q.fwd_atomic) |-> (evt_state == ST_I));

    // R13: at most one completion per event.
    a_r13_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_q.cpl_load, act_q.cpl_store, act_q.cpl_flush, act_q.cpl_evict}));

    // R13: no strobe without an event.
    a_r13_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> (act_q == '0));

endmodule

// File: rtl/l1_line_ctrl.sv
// Top of the L1 line state controller: picks one event per cycle
// (response, then replacement, then core), holds off data ops to a line
// pending an atomic, updates the line table and registers the result.
// Assumes: line address equals line index; responses are never held off.
module l1_line_ctrl
    import l1ls_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int MASK_W = 4,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              bypass_mode,
    input  logic              core_valid,
    output logic              core_ready,
    input  logic [2:0]        core_op,
    input  logic [LINE_W-1:0] core_line,
    input  logic [MASK_W-1:0] core_mask,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic              rsp_is_wback,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic              repl_valid,
    output logic              repl_ready,
    input  logic [LINE_W-1:0] repl_line,
    output logic              evt_valid,
    output logic [LINE_W-1:0] evt_line,
    output logic [2:0]        evt_state,
    output logic              act_alloc,
    output logic              act_inval,
    output logic              cpl_load,
    output logic              cpl_store,
    output logic              cpl_flush,
    output logic              cpl_evict,
    output logic              wt_valid,
    output logic [MASK_W-1:0] wt_mask,
    output logic              fwd_valid,
    output logic              fwd_atomic,
    output logic [MASK_W-1:0] fwd_mask
);

    logic [LINE_W-1:0] sel_line;
    logic [MASK_W-1:0] sel_mask;
    line_st_e          cur_st;
    logic [MASK_W-1:0] cur_mask;
    logic              core_data_op;
    logic              core_blocked;
    evt_e              core_ev;
    evt_e              ev;
    logic              fire;
    line_st_e          nxt_st;
    logic [MASK_W-1:0] nxt_mask;
    act_t              act_n;
    logic [MASK_W-1:0] wt_mask_n;
    logic [MASK_W-1:0] fwd_mask_n;
    line_st_e          evt_state_q;
    act_t              act_q;

    // Purpose: choose which line the table reads, by source priority.
    always_comb begin
        if (rsp_valid) begin
            sel_line = rsp_line;
            sel_mask = '0;
        end else if (repl_valid) begin
            sel_line = repl_line;
            sel_mask = '0;
        end else begin
            sel_line = core_line;
            sel_mask = core_mask;
        end
    end

    // Purpose: classify the core request, including the store path choice.
    always_comb begin
        core_data_op = core_op_e'(core_op) inside {OP_LOAD, OP_STORE, OP_SPILL, OP_ATOMIC};
        case (core_op_e'(core_op))
            OP_LOAD:   core_ev = EV_LOAD;
            OP_STORE:  core_ev = (bypass_mode || !wb_mode) ? EV_ST_WT : EV_ST_WB;
            OP_SPILL:  core_ev = bypass_mode ? EV_ST_WT : EV_SPILL;
            OP_ATOMIC: core_ev = EV_ATOMIC;
            OP_FLUSH:  core_ev = EV_FLUSH;
            OP_EVICT:  core_ev = EV_EVICT;
            default:   core_ev = EV_NOP;
        endcase
    end

    // Purpose: handshakes and the single event of this cycle.
    always_comb begin
        core_blocked = core_data_op && (cur_st == ST_A);
        rsp_ready    = 1'b1;
        repl_ready   = !rsp_valid;
        core_ready   = !rsp_valid && !repl_valid && !core_blocked;
        if (rsp_valid)
            ev = rsp_is_wback ? EV_WB_ACK : (bypass_mode ? EV_RD_BYP : EV_RD_ACK);
        else if (repl_valid)
            ev = EV_REPL;
        else if (core_valid && !core_blocked)
            ev = core_ev;
        else
            ev = EV_NONE;
        fire = (ev != EV_NONE);
    end

    l1ls_state_table #(.LINES(LINES), .MASK_W(MASK_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_line  (sel_line),
        .rd_state (cur_st),
        .rd_mask  (cur_mask),
        .wr_en    (fire),
        .wr_line  (sel_line),
        .wr_state (nxt_st),
        .wr_mask  (nxt_mask)
    );

    l1ls_next #(.MASK_W(MASK_W)) u_next (
        .ev       (ev),
        .cur_st   (cur_st),
        .cur_mask (cur_mask),
        .req_mask (sel_mask),
        .nxt_st   (nxt_st),
        .nxt_mask (nxt_mask),
        .act      (act_n),
        .wt_mask  (wt_mask_n),
        .fwd_mask (fwd_mask_n)
    );

    l1ls_issue #(.LINES(LINES), .MASK_W(MASK_W)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .line_in     (sel_line),
        .st_in       (nxt_st),
        .act_in      (act_n),
        .wt_mask_in  (wt_mask_n),
        .fwd_mask_in (fwd_mask_n),
        .evt_valid   (evt_valid),
        .evt_line    (evt_line),
        .evt_state   (evt_state_q),
        .act_q       (act_q),
        .wt_mask_q   (wt_mask),
        .fwd_mask_q  (fwd_mask)
    );

    // Purpose: flatten the registered actions onto the ports.
    always_comb begin
        evt_state  = evt_state_q;
        act_alloc  = act_q.alloc;
        act_inval  = act_q.inval;
        cpl_load   = act_q.cpl_load;
        cpl_store  = act_q.cpl_store;
        cpl_flush  = act_q.cpl_flush;
        cpl_evict  = act_q.cpl_evict;
        wt_valid   = act_q.wt;
        fwd_valid  = act_q.fwd;
        fwd_atomic = act_q.fwd_atomic;
    end

    // R7: a held-off core request, alone, produces no event.
    a_r7_stall_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && !core_ready && !rsp_valid && !repl_valid) |=> !evt_valid);

    // R13: a response is served before anything else.
    a_r13_response_first: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (evt_valid && (evt_line == $past(rsp_line))));

endmodule

// File: tb/l1_line_ctrl_test.sv
// Sweep of every line state against every event kind with two mask
// patterns; expected results computed from the requirements.
module l1_line_ctrl_test;

    localparam int LINES = 8;

    localparam int K_LOAD = 0, K_ST_WB = 1, K_ST_WT = 2, K_ST_BYP = 3,
                   K_SPILL = 4, K_ATOMIC = 5, K_FLUSH = 6, K_EVICT = 7,
                   K_REPL = 8, K_RDACK = 9, K_RDBYP = 10, K_WBACK = 11;

    localparam logic [2:0] SI = 3'd0, SV = 3'd1, SW = 3'd2, SM = 3'd3, SL = 3'd4, SA = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wb_mode = 1'b0, bypass_mode = 1'b0;
    logic       core_valid = 1'b0;
    logic       core_ready;
    logic [2:0] core_op = '0;
    logic [2:0] core_line = '0;
    logic [3:0] core_mask = '0;
    logic       rsp_valid = 1'b0, rsp_ready, rsp_is_wback = 1'b0;
    logic [2:0] rsp_line = '0;
    logic       repl_valid = 1'b0, repl_ready;
    logic [2:0] repl_line = '0;
    logic       evt_valid;
    logic [2:0] evt_line, evt_state;
    logic       act_alloc, act_inval, cpl_load, cpl_store, cpl_flush, cpl_evict;
    logic       wt_valid, fwd_valid, fwd_atomic;
    logic [3:0] wt_mask, fwd_mask;

    int checks = 0;
    int errors = 0;
    logic [2:0] mst [LINES];
    logic [3:0] mmk [LINES];

    always #10 clk = ~clk;

    l1_line_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .bypass_mode(bypass_mode),
        .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
        .core_line(core_line), .core_mask(core_mask),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_is_wback(rsp_is_wback),
        .rsp_line(rsp_line), .repl_valid(repl_valid), .repl_ready(repl_ready),
        .repl_line(repl_line), .evt_valid(evt_valid), .evt_line(evt_line),
        .evt_state(evt_state), .act_alloc(act_alloc), .act_inval(act_inval),
        .cpl_load(cpl_load), .cpl_store(cpl_store), .cpl_flush(cpl_flush),
        .cpl_evict(cpl_evict), .wt_valid(wt_valid), .wt_mask(wt_mask),
        .fwd_valid(fwd_valid), .fwd_atomic(fwd_atomic), .fwd_mask(fwd_mask)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [19:0] observed();
        return {evt_state, act_alloc, act_inval, cpl_load, cpl_store, cpl_flush,
                cpl_evict, wt_valid, fwd_valid, fwd_atomic, wt_mask, fwd_mask};
    endfunction

    function automatic string rtag(input int k, input logic [2:0] s);
        if (s == SA && k <= K_ATOMIC) return "R7";
        case (k)
            K_LOAD:   return (s == SW) ? "R8" : "R2";
            K_ST_WB:  return "R3";
            K_ST_WT, K_ST_BYP: return "R4";
            K_SPILL:  return "R5";
            K_ATOMIC: return "R6";
            K_FLUSH:  return "R10";
            K_EVICT:  return "R11";
            K_REPL:   return "R9";
            K_RDACK:  return (s == SA) ? "R12" : "R2";
            K_RDBYP:  return "R12";
            default:  return "R13";
        endcase
    endfunction

    // Expected outputs and new line contents, written from the requirements.
    function automatic logic [19:0] model(input int k, input logic [2:0] s, input logic [3:0] m,
                                          input logic [3:0] rq, output logic [2:0] ns,
                                          output logic [3:0] nm);
        logic al, iv, cl, cs, cf, ce, wt, fw, fa;
        logic [3:0] wm, fm, mg;
        logic cov, dirty, clean;
        {al, iv, cl, cs, cf, ce, wt, fw, fa} = '0;
        wm = '0; fm = '0; ns = s; nm = m;
        mg = m | rq;
        cov = ((rq & ~m) == 4'h0);
        dirty = (s == SW) || (s == SM);
        clean = (s == SI) || (s == SV) || (s == SL);
        case (k)
            K_LOAD: begin
                if (s == SI) begin fw = 1; fm = 4'hF; end
                else if (s == SW) begin
                    wt = 1; wm = m; iv = 1; ns = SI; nm = 0;
                    if (cov) cl = 1; else begin fw = 1; fm = 4'hF; end
                end else cl = 1;
            end
            K_ST_WB: begin
                cs = 1; nm = mg;
                if (s == SI) begin al = 1; ns = SW; end
                else if (s == SV) ns = SM;
            end
            K_ST_WT, K_ST_BYP: begin
                cs = 1;
                if (clean) begin al = (s == SI); wt = 1; wm = mg; iv = 1; ns = SI; nm = 0; end
                else nm = mg;
            end
            K_SPILL: begin
                cs = 1; nm = mg;
                if (clean) begin al = (s == SI); ns = SL; end
            end
            K_ATOMIC: begin
                fw = 1; fa = 1; fm = rq; ns = SA; nm = 0;
                if (dirty || s == SL) begin wt = 1; wm = m; iv = 1; end
            end
            K_FLUSH: begin
                cf = 1;
                if (dirty) begin wt = 1; wm = m; iv = 1; ns = SI; nm = 0; end
            end
            K_EVICT: begin
                ce = 1;
                if (s == SV) begin iv = 1; ns = SI; end
                else if (dirty) ns = SW;
            end
            K_REPL: begin
                if (dirty || s == SL) begin wt = 1; wm = m; iv = 1; ns = SI; nm = 0; end
                else if (s == SV) begin iv = 1; ns = SI; end
                else if (s == SA) iv = 1;
            end
            K_RDACK: begin
                if (s == SA) begin cs = 1; iv = 1; ns = SI; nm = 0; end
                else begin
                    cl = 1;
                    if (s == SI) begin al = 1; ns = SV; end
                    else if (dirty) ns = SM;
                end
            end
            K_RDBYP: begin
                if (s == SA) begin cs = 1; ns = SI; nm = 0; end
                else cl = 1;
            end
            default: ;
        endcase
        return {ns, al, iv, cl, cs, cf, ce, wt, fw, fa, wm, fm};
    endfunction

    // Drive one event, check the handshake, then the registered result.
    task automatic run_ev(input int k, input int ln, input logic [3:0] rq);
        logic [2:0] ns;
        logic [3:0] nm;
        logic [19:0] exp;
        logic stall;
        string tag;
        stall = (mst[ln] == SA) && (k <= K_ATOMIC);
        tag = rtag(k, mst[ln]);
        exp = model(k, mst[ln], mmk[ln], rq, ns, nm);
        @(negedge clk);
        if (k <= K_EVICT) begin
            core_valid = 1'b1;
            core_line = 3'(ln);
            core_mask = rq;
            wb_mode = (k != K_ST_WT);
            bypass_mode = (k == K_ST_BYP);
            case (k)
                K_LOAD: core_op = 3'd0;
                K_ST_WB, K_ST_WT, K_ST_BYP: core_op = 3'd1;
                K_SPILL: core_op = 3'd2;
                K_ATOMIC: core_op = 3'd3;
                K_FLUSH: core_op = 3'd4;
                default: core_op = 3'd5;
            endcase
        end else if (k == K_REPL) begin
            repl_valid = 1'b1;
            repl_line = 3'(ln);
        end else begin
            rsp_valid = 1'b1;
            rsp_line = 3'(ln);
            rsp_is_wback = (k == K_WBACK);
            bypass_mode = (k == K_RDBYP);
        end
        #1;
        if (k <= K_EVICT)
            chk(core_ready == !stall, tag, 32'(core_ready), 32'(!stall));
        else if (k == K_REPL)
            chk(repl_ready == 1'b1, "R13", 32'(repl_ready), 32'd1);
        else
            chk(rsp_ready == 1'b1, "R13", 32'(rsp_ready), 32'd1);
        @(negedge clk);
        core_valid = 1'b0; repl_valid = 1'b0; rsp_valid = 1'b0;
        rsp_is_wback = 1'b0; bypass_mode = 1'b0; wb_mode = 1'b0;
        if (stall) begin
            chk(evt_valid == 1'b0, "R7", 32'(evt_valid), 32'd0);
        end else begin
            chk(evt_valid && evt_line == 3'(ln), tag, {evt_valid, evt_line}, {1'b1, 3'(ln)});
            chk(observed() == exp, tag, 32'(observed()), 32'(exp));
            mst[ln] = ns;
            mmk[ln] = nm;
        end
    endtask

    task automatic goto_state(input int ln, input logic [2:0] s);
        if (mst[ln] == SA) run_ev(K_RDACK, ln, 4'h0);
        else if (mst[ln] != SI) run_ev(K_REPL, ln, 4'h0);
        case (s)
            SV: run_ev(K_RDACK, ln, 4'h0);
            SW: run_ev(K_ST_WB, ln, 4'h3);
            SM: begin run_ev(K_ST_WB, ln, 4'h3); run_ev(K_RDACK, ln, 4'h0); end
            SL: run_ev(K_SPILL, ln, 4'h3);
            SA: run_ev(K_ATOMIC, ln, 4'h3);
            default: ;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog: actual hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ln;
        for (int i = 0; i < LINES; i++) begin mst[i] = SI; mmk[i] = 4'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk({evt_valid, observed()} == 21'(0), "R1", 32'({evt_valid, observed()}), 32'd0);
        chk(core_ready == 1'b1, "R1", 32'(core_ready), 32'd1);
        // Every line starts invalid: a load sends a block read (R1, R2).
        for (int i = 0; i < LINES; i++) run_ev(K_LOAD, i, 4'h1);
        // Sweep: state x event x mask pattern.
        ln = 0;
        for (int s = 0; s < 6; s++) begin
            for (int k = 0; k <= K_WBACK; k++) begin
                for (int mv = 0; mv < 2; mv++) begin
                    goto_state(ln, 3'(s));
                    run_ev(k, ln, (mv == 0) ? 4'h1 : 4'h4);
                    ln = (ln + 1) % LINES;
                end
            end
        end
        // R13: priority with all three sources present.
        goto_state(1, SI);
        goto_state(2, SI);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_line = 3'd1;
        repl_valid = 1'b1; repl_line = 3'd2;
        core_valid = 1'b1; core_op = 3'd0; core_line = 3'd3; core_mask = 4'h1;
        #1;
        chk({rsp_ready, repl_ready, core_ready} == 3'b100, "R13",
            32'({rsp_ready, repl_ready, core_ready}), 32'b100);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(evt_line == 3'd1 && evt_state == SV && cpl_load, "R13",
            32'({evt_line, evt_state, cpl_load}), 32'({3'd1, SV, 1'b1}));
        mst[1] = SV;
        #1;
        chk({repl_ready, core_ready} == 2'b10, "R13", 32'({repl_ready, core_ready}), 32'b10);
        @(negedge clk);
        repl_valid = 1'b0; core_valid = 1'b0;
        chk(evt_line == 3'd2 && evt_state == SI && !act_inval, "R13",
            32'({evt_line, evt_state, act_inval}), 32'({3'd2, SI, 1'b0}));
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule